// File: doc/BRIEF.md
# Vector Clip-Low Select Unit

This block performs the low-half step of a two-step clip across a vector of signed lanes. A preceding clip-high step leaves five flags per lane: a not-equal flag, a carry/sign flag, an extra clip-compare flag, a compare flag and a clip flag. The preceding step writes these into the block's flag bank through a load strobe.

When an operation strobe arrives, each lane forms a conditionally negated copy of VT. It then compares that copy against VS using an unsigned test and a carry-out test, and picks either the negated copy or VS as the lane result. Lanes whose high half was marked not-equal keep their earlier compare and clip flags.

The result appears on the destination output and on the low accumulator slice output. Both are registered one clock after the strobe. The flag bank is updated in the same edge: clip and compare take the newly decided values, and the other three flags clear. Results are then ready for the next clip step.

Top module: `clip_low_sel`

## Requirements
- R1: While `rst` is high, on every rising edge `res_valid`, `vd_o`, `acc_lo_o` and all five flag outputs become zero.
- R2: A rising edge with `flg_wr` high and `op_valid` low copies the five `*_wr` vectors into the flag bank, visible on the `*_q` outputs after that edge; bit i of each vector belongs to lane i.
- R3: Per lane, with sn equal to the lane's carry flag, the candidate value VC is VT when sn is 0 and (2^W − VT) mod 2^W when sn is 1, so the most negative value maps to itself.
- R4: The new compare flag of a lane is le_c when the not-equal flag is 0 and sn is 1, and otherwise the old compare flag. le_c is (lz OR uz) when the extra flag is 1 and (lz AND uz) when it is 0. Here lz means VS equals VC, and uz means the unsigned sum VS+VT is below 2^W.
- R5: The new clip flag of a lane is (VS >= VC, unsigned) when the not-equal flag is 0 and sn is 0, and otherwise the old clip flag.
- R6: Each lane of `vd_o` is VC when the selector is 1 and VS when it is 0. The selector is the new compare flag if sn is 1 and the new clip flag if sn is 0. Lane i occupies bits [i*W +: W].
- R7: After an operation edge, the not-equal, carry and extra flags of every lane read 0.
- R8: `res_valid` is high exactly in the cycle after an edge with `op_valid` high, and `acc_lo_o` carries the same value as `vd_o` after each operation.
- R9: An edge without `op_valid` leaves `vd_o` and `acc_lo_o` unchanged.
- R10: When `flg_wr` and `op_valid` are both high on one edge, the operation's flag update is kept and the load is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flg_wr | input | 1 | Load strobe for the flag bank |
| ne_wr | input | LANES | Not-equal flags to load |
| co_wr | input | LANES | Carry/sign flags to load |
| ext_wr | input | LANES | Extra clip-compare flags to load |
| cmp_wr | input | LANES | Compare flags to load |
| clp_wr | input | LANES | Clip flags to load |
| op_valid | input | 1 | Start one clip-low operation |
| vs_i | input | LANES*LANE_W | VS vector, lane i at [i*LANE_W +: LANE_W] |
| vt_i | input | LANES*LANE_W | VT vector, same layout |
| res_valid | output | 1 | Result registered this cycle |
| vd_o | output | LANES*LANE_W | Destination vector |
| acc_lo_o | output | LANES*LANE_W | Low accumulator slice |
| ne_q | output | LANES | Not-equal flags held |
| co_q | output | LANES | Carry/sign flags held |
| ext_q | output | LANES | Extra clip-compare flags held |
| cmp_q | output | LANES | Compare flags held |
| clp_q | output | LANES | Clip flags held |

## Verification
The bench builds the unit with LANES=2 and LANE_W=4. At that size one lane has only 8192 distinct combinations of VS, VT and the five incoming flags, so lane 0 is swept through all of them. Lane 1 is driven at the same time through an odd-stride permutation of the same space. This brings every wrap of the carry-out test and every equality case into reach, including the negation of the most negative value. It also covers each way the extra flag and the not-equal flag steer the compare and clip decisions. Directed steps add a coincident load and operation, idle cycles, and reset.

// File: rtl/clo_pkg.sv
package clo_pkg;

  // Per-lane flag state held between clip steps.
  typedef struct packed {
    logic ne;   // high half of the lane was not equal
    logic co;   // carry / sign of the lane
    logic ext;  // extra clip-compare flag
    logic cmp;  // compare (low-side) flag
    logic clp;  // clip (high-side) flag
  } clo_flag_t;

  localparam int unsigned FLAG_BITS = $bits(clo_flag_t);

endpackage

// File: rtl/clo_lane.sv
module clo_lane
  import clo_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] vs,
  input  logic [W-1:0] vt,
  input  clo_flag_t    fin,
  output logic [W-1:0] vd,
  output logic         le_n,
  output logic         ge_n
);

  logic         sn;
  logic         eq;
  logic [W-1:0] vc;
  logic [W:0]   sum;
  logic [W-1:0] diff;
  logic         uz;
  logic         lz;
  logic         le_c;
  logic         ge_c;
  logic         sel;

  assign sn = fin.co;
  assign eq = ~fin.ne;

  // conditional two's-complement negation of VT
  assign vc = (vt ^ {W{sn}}) + {{(W-1){1'b0}}, sn};

  // carry-out of the raw unsigned sum, and wrap-around zero difference
  assign sum  = {1'b0, vs} + {1'b0, vt};
  assign uz   = ~sum[W];
  assign diff = vs - vc;
  assign lz   = (diff == '0);

  assign le_c = fin.ext ? (lz | uz) : (lz & uz);
  assign ge_c = (vs >= vc);

  assign le_n = (eq &  sn) ? le_c : fin.cmp;
  assign ge_n = (eq & ~sn) ? ge_c : fin.clp;

  assign sel = sn ? le_n : ge_n;
  assign vd  = sel ? vc : vs;

endmodule

// File: rtl/clo_lane_array.sv
module clo_lane_array
  import clo_pkg::*;
#(
  parameter int unsigned LANES  = 8,
  parameter int unsigned LANE_W = 16,
  localparam int unsigned VEC_W = LANES * LANE_W
) (
  input  logic [VEC_W-1:0]          vs_vec,
  input  logic [VEC_W-1:0]          vt_vec,
  input  clo_flag_t [LANES-1:0]     flags,
  output logic [VEC_W-1:0]          vd_vec,
  output logic [LANES-1:0]          le_vec,
  output logic [LANES-1:0]          ge_vec
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    clo_lane #(.W(LANE_W)) lane_i (
      .vs   (vs_vec[i*LANE_W +: LANE_W]),
      .vt   (vt_vec[i*LANE_W +: LANE_W]),
      .fin  (flags[i]),
      .vd   (vd_vec[i*LANE_W +: LANE_W]),
      .le_n (le_vec[i]),
      .ge_n (ge_vec[i])
    );
  end

endmodule

// File: rtl/clo_flag_bank.sv
module clo_flag_bank
  import clo_pkg::*;
#(
  parameter int unsigned LANES = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ld_en,
  input  clo_flag_t [LANES-1:0] ld_val,
  input  logic                  op_en,
  input  logic [LANES-1:0]      le_new,
  input  logic [LANES-1:0]      ge_new,
  output clo_flag_t [LANES-1:0] st
);

  for (genvar i = 0; i < LANES; i++) begin : g_flag
    clo_flag_t q;

    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (op_en) begin
        // operation update wins over a coincident load
        q.ne  <= 1'b0;
        q.co  <= 1'b0;
        q.ext <= 1'b0;
        q.cmp <= le_new[i];
        q.clp <= ge_new[i];
      end else if (ld_en) begin
        q <= ld_val[i];
      end
    end

    assign st[i] = q;
  end

endmodule

// File: rtl/clo_result_reg.sv
module clo_result_reg #(
  parameter int unsigned VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_en,
  input  logic [VEC_W-1:0] vd_n,
  output logic             valid_q,
  output logic [VEC_W-1:0] vd_q,
  output logic [VEC_W-1:0] acc_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      vd_q    <= '0;
      acc_q   <= '0;
    end else begin
      valid_q <= op_en;
      if (op_en) begin
        vd_q  <= vd_n;
        acc_q <= vd_n;
      end
    end
  end

endmodule

// File: rtl/clip_low_sel.sv
module clip_low_sel
  import clo_pkg::*;
#(
  parameter int unsigned LANES  = 8,
  parameter int unsigned LANE_W = 16,
  localparam int unsigned VEC_W = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flg_wr,
  input  logic [LANES-1:0] ne_wr,
  input  logic [LANES-1:0] co_wr,
  input  logic [LANES-1:0] ext_wr,
  input  logic [LANES-1:0] cmp_wr,
  input  logic [LANES-1:0] clp_wr,
  input  logic             op_valid,
  input  logic [VEC_W-1:0] vs_i,
  input  logic [VEC_W-1:0] vt_i,
  output logic             res_valid,
  output logic [VEC_W-1:0] vd_o,
  output logic [VEC_W-1:0] acc_lo_o,
  output logic [LANES-1:0] ne_q,
  output logic [LANES-1:0] co_q,
  output logic [LANES-1:0] ext_q,
  output logic [LANES-1:0] cmp_q,
  output logic [LANES-1:0] clp_q
);

  clo_flag_t [LANES-1:0] ld_val;
  clo_flag_t [LANES-1:0] st;
  logic [LANES-1:0]      le_new;
  logic [LANES-1:0]      ge_new;
  logic [VEC_W-1:0]      vd_n;

  for (genvar i = 0; i < LANES; i++) begin : g_map
    assign ld_val[i] = '{ne: ne_wr[i], co: co_wr[i], ext: ext_wr[i],
                         cmp: cmp_wr[i], clp: clp_wr[i]};
    assign ne_q[i]  = st[i].ne;
    assign co_q[i]  = st[i].co;
    assign ext_q[i] = st[i].ext;
    assign cmp_q[i] = st[i].cmp;
    assign clp_q[i] = st[i].clp;
  end

  clo_lane_array #(.LANES(LANES), .LANE_W(LANE_W)) lanes_i (
    .vs_vec (vs_i),
    .vt_vec (vt_i),
    .flags  (st),
    .vd_vec (vd_n),
    .le_vec (le_new),
    .ge_vec (ge_new)
  );

  clo_flag_bank #(.LANES(LANES)) flags_i (
    .clk    (clk),
    .rst    (rst),
    .ld_en  (flg_wr),
    .ld_val (ld_val),
    .op_en  (op_valid),
    .le_new (le_new),
    .ge_new (ge_new),
    .st     (st)
  );

  clo_result_reg #(.VEC_W(VEC_W)) res_i (
    .clk     (clk),
    .rst     (rst),
    .op_en   (op_valid),
    .vd_n    (vd_n),
    .valid_q (res_valid),
    .vd_q    (vd_o),
    .acc_q   (acc_lo_o)
  );

endmodule

// File: rtl/clip_low_sel_chk.sv
module clip_low_sel_chk #(
  parameter int unsigned LANES  = 8,
  parameter int unsigned LANE_W = 16,
  localparam int unsigned VEC_W = LANES * LANE_W
) (
  input logic             clk,
  input logic             rst,
  input logic             flg_wr,
  input logic [LANES-1:0] ne_wr,
  input logic [LANES-1:0] co_wr,
  input logic [LANES-1:0] ext_wr,
  input logic [LANES-1:0] cmp_wr,
  input logic [LANES-1:0] clp_wr,
  input logic             op_valid,
  input logic             res_valid,
  input logic [VEC_W-1:0] vd_o,
  input logic [VEC_W-1:0] acc_lo_o,
  input logic [LANES-1:0] ne_q,
  input logic [LANES-1:0] co_q,
  input logic [LANES-1:0] ext_q,
  input logic [LANES-1:0] cmp_q,
  input logic [LANES-1:0] clp_q
);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!res_valid && vd_o == '0 && acc_lo_o == '0 &&
             ne_q == '0 && co_q == '0 && ext_q == '0 &&
             cmp_q == '0 && clp_q == '0));

  // R2
  flag_load_chk: assert property (@(posedge clk) disable iff (rst)
    (flg_wr && !op_valid) |=> (ne_q == $past(ne_wr) && co_q == $past(co_wr) &&
                               ext_q == $past(ext_wr) && cmp_q == $past(cmp_wr) &&
                               clp_q == $past(clp_wr)));

  // R7
  flags_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> (ne_q == '0 && co_q == '0 && ext_q == '0));

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> res_valid);

  // R8
  valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !res_valid);

  // R8
  acc_match_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (acc_lo_o == vd_o));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(vd_o) && $stable(acc_lo_o)));

  // R10
  load_dropped_chk: assert property (@(posedge clk) disable iff (rst)
    (flg_wr && op_valid) |=> (ext_q == '0 && co_q == '0));

endmodule

bind clip_low_sel clip_low_sel_chk #(.LANES(LANES), .LANE_W(LANE_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .flg_wr    (flg_wr),
  .ne_wr     (ne_wr),
  .co_wr     (co_wr),
  .ext_wr    (ext_wr),
  .cmp_wr    (cmp_wr),
  .clp_wr    (clp_wr),
  .op_valid  (op_valid),
  .res_valid (res_valid),
  .vd_o      (vd_o),
  .acc_lo_o  (acc_lo_o),
  .ne_q      (ne_q),
  .co_q      (co_q),
  .ext_q     (ext_q),
  .cmp_q     (cmp_q),
  .clp_q     (clp_q)
);

// File: tb/clip_low_sel_tb_top.sv
module clip_low_sel_tb_top;

  localparam int LANES  = 2;
  localparam int LANE_W = 4;
  localparam int VEC_W  = LANES * LANE_W;
  localparam int MASK   = (1 << LANE_W) - 1;
  localparam int SPACE  = 1 << (2 * LANE_W + 5);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             flg_wr = 1'b0;
  logic [LANES-1:0] ne_wr = '0, co_wr = '0, ext_wr = '0, cmp_wr = '0, clp_wr = '0;
  logic             op_valid = 1'b0;
  logic [VEC_W-1:0] vs_i = '0, vt_i = '0;
  logic             res_valid;
  logic [VEC_W-1:0] vd_o, acc_lo_o;
  logic [LANES-1:0] ne_q, co_q, ext_q, cmp_q, clp_q;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  clip_low_sel #(.LANES(LANES), .LANE_W(LANE_W)) dut_i (
    .clk(clk), .rst(rst), .flg_wr(flg_wr),
    .ne_wr(ne_wr), .co_wr(co_wr), .ext_wr(ext_wr), .cmp_wr(cmp_wr), .clp_wr(clp_wr),
    .op_valid(op_valid), .vs_i(vs_i), .vt_i(vt_i),
    .res_valid(res_valid), .vd_o(vd_o), .acc_lo_o(acc_lo_o),
    .ne_q(ne_q), .co_q(co_q), .ext_q(ext_q), .cmp_q(cmp_q), .clp_q(clp_q)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Reference per lane, from the requirements. Combo bits:
  // [3:0] vs, [7:4] vt, [8] ne, [9] co, [10] ext, [11] cmp, [12] clp
  function automatic void model(input int c, output int vd, output int le, output int ge);
    int vs, vt, ne, sn, ext, cmp, clp, vc, uz, lz, lec, gec, sel;
    vs  = c & MASK;
    vt  = (c >> LANE_W) & MASK;
    ne  = (c >> (2*LANE_W)) & 1;
    sn  = (c >> (2*LANE_W+1)) & 1;
    ext = (c >> (2*LANE_W+2)) & 1;
    cmp = (c >> (2*LANE_W+3)) & 1;
    clp = (c >> (2*LANE_W+4)) & 1;
    vc  = sn ? ((MASK + 1 - vt) & MASK) : vt;            // R3
    uz  = ((vs + vt) < (MASK + 1)) ? 1 : 0;
    lz  = (vs == vc) ? 1 : 0;
    lec = ext ? (lz | uz) : (lz & uz);
    gec = (vs >= vc) ? 1 : 0;
    le  = (!ne && sn)  ? lec : cmp;                       // R4
    ge  = (!ne && !sn) ? gec : clp;                       // R5
    sel = sn ? le : ge;
    vd  = sel ? vc : vs;                                  // R6
  endfunction

  task automatic drive_lane(input int l, input int c);
    vs_i[l*LANE_W +: LANE_W] = LANE_W'(c & MASK);
    vt_i[l*LANE_W +: LANE_W] = LANE_W'((c >> LANE_W) & MASK);
    ne_wr[l]  = 1'((c >> (2*LANE_W))   & 1);
    co_wr[l]  = 1'((c >> (2*LANE_W+1)) & 1);
    ext_wr[l] = 1'((c >> (2*LANE_W+2)) & 1);
    cmp_wr[l] = 1'((c >> (2*LANE_W+3)) & 1);
    clp_wr[l] = 1'((c >> (2*LANE_W+4)) & 1);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int c [LANES];
    int evd, ele, ege;
    logic [VEC_W-1:0] exp_vd, prev_vd;
    logic [LANES-1:0] exp_le, exp_ge;

    @(negedge clk);
    step();
    // R1 reset state
    chk("R1 res_valid", res_valid, 0);
    chk("R1 vd_o", vd_o, 0);
    chk("R1 acc_lo_o", acc_lo_o, 0);
    chk("R1 flags", {ne_q, co_q, ext_q, cmp_q, clp_q}, 0);
    rst = 1'b0;
    prev_vd = '0;

    for (int k = 0; k < SPACE; k++) begin
      c[0] = k;
      c[1] = (k * 37 + 11) % SPACE;
      for (int l = 0; l < LANES; l++) drive_lane(l, c[l]);
      flg_wr = 1'b1;
      step();
      flg_wr = 1'b0;
      // R2 load visible; R9 result held across a load-only edge
      chk("R2 flag load", {ne_q, co_q, ext_q, cmp_q, clp_q},
          {ne_wr, co_wr, ext_wr, cmp_wr, clp_wr});
      chk("R9 hold on load", vd_o, prev_vd);
      op_valid = 1'b1;
      step();
      op_valid = 1'b0;
      for (int l = 0; l < LANES; l++) begin
        model(c[l], evd, ele, ege);
        exp_vd[l*LANE_W +: LANE_W] = LANE_W'(evd);
        exp_le[l] = 1'(ele);
        exp_ge[l] = 1'(ege);
      end
      chk("R3/R6 vd_o", vd_o, exp_vd);
      chk("R4 cmp_q", cmp_q, exp_le);
      chk("R5 clp_q", clp_q, exp_ge);
      chk("R7 cleared flags", {ne_q, co_q, ext_q}, 0);
      chk("R8 acc and valid", {res_valid, acc_lo_o}, {1'b1, exp_vd});
      prev_vd = vd_o;
    end

    // R9 idle cycles keep results, valid low
    for (int n = 0; n < 3; n++) begin
      step();
      chk("R9 idle hold", {res_valid, vd_o, acc_lo_o}, {1'b0, prev_vd, prev_vd});
    end

    // R3 directed: lane 0 vs=2 vt=3 co=1 ext=1 -> VC = 13 selected
    // R10 coincident load with all-ones flags is dropped
    drive_lane(0, 2 | (3 << 4) | (1 << 9) | (1 << 10));
    drive_lane(1, 5 | (5 << 4));
    flg_wr = 1'b1;
    step();
    ne_wr = '1; co_wr = '1; ext_wr = '1; cmp_wr = '1; clp_wr = '1;
    op_valid = 1'b1;
    step();
    flg_wr = 1'b0;
    op_valid = 1'b0;
    chk("R3 negated VT", vd_o[3:0], 13);
    chk("R10 load ignored", {ne_q, co_q, ext_q}, 0);
    // lane0 cmp=1 (le_c), clp=0 (old); lane1 cmp=0 (old), clp=1 (5>=5)
    chk("R10 op flags kept", {cmp_q, clp_q}, {2'b01, 2'b10});

    // R1 reset again after activity
    rst = 1'b1;
    step();
    chk("R1 reset after use", {res_valid, vd_o, acc_lo_o, ne_q, co_q, ext_q, cmp_q, clp_q}, 0);
    rst = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule